// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block models the column side of a synchronous DRAM device. It runs READ and WRITE bursts against a small internal array, organised as banks of columns. A command, a bank, a start column, write data and a byte write mask are presented on each rising clock edge. Read beats come out on a registered data bus with a valid flag. The burst length is taken from a configuration input when a burst starts. The column sequence walks upward and wraps inside the aligned block of that length.

A sampled clock-enable input, `cke`, gives the clock suspend behaviour. The suspend only applies while a burst is live, meaning beats are still pending or read data is being driven. If `cke` is low on an edge that leaves a burst live, the next internal edge is frozen. The engine then behaves as if that edge never happened. The burst position holds, any read data on the bus stays driven, and everything on the command, address and write-data inputs is dropped. The `suspended` flag is high for exactly the cycle that ends on a frozen edge.

The read stream is valid-only and has no ready input. Flow control is the `cke` pin. Holding it low stalls the stream at its current beat, so it acts as the back-pressure mechanism. Control and status pins are plain levels.

Top module: `sbe_burst_engine`

## Requirements
- R1: While `rst_n` is low and after its release, `rd_valid`, `busy` and `suspended` are 0, and every array word reads as 0.
- R2: `blen_sel` values 0, 1, 2 and 3 select burst lengths 1, 2, 4 and 8, sampled on the command edge. A READ accepted on edge k drives beat 0 on `rd_data` with `rd_valid`=1 after edge k, and beat i after the i-th following unfrozen edge. Beat i uses column (start & ~(L-1)) | ((start+i) & (L-1)) for length L. `rd_valid` drops after the first unfrozen edge past the last beat.
- R3: A WRITE stores the `wr_data` present on its command edge at the start column, and the data on each following unfrozen edge at the next column of the R2 sequence. A `wr_mask` bit j set to 1 keeps byte j (bits 8j+7..8j) of the old word.
- R4: If `cke` is 0 on an edge after which a burst is live (beats pending or `rd_valid`=1), the next edge is frozen. `suspended` is 1 during the cycle that ends on that edge.
- R5: A frozen edge changes nothing: `rd_data`, `rd_valid`, `busy` and the burst position keep their values.
- R6: On a frozen edge, `cmd`, `bank`, `col`, `wr_data` and `wr_mask` are ignored. A write beat that would have fallen there is discarded, and the same column takes the write data of the next unfrozen edge.
- R7: An edge that samples `cke`=1 is followed by an unfrozen edge, so `suspended` is 0 in the cycle after it.
- R8: With no burst live, `cke`=0 and a NOP (`cmd`=0, or the unused code 3) on an edge leave the engine idle with `suspended` 0.
- R9: A READ (`cmd`=1) or WRITE (`cmd`=2) accepted on an unfrozen edge ends any current burst and restarts the sequence at its own column. A WRITE clears `rd_valid` on that edge.
- R10: `busy` is 1 exactly while a burst is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Sampled clock enable; low freezes the next internal edge during a burst |
| cmd | input | 2 | 0 NOP, 1 READ, 2 WRITE, 3 treated as NOP |
| bank | input | $clog2(BANKS) | Bank of a new burst |
| col | input | $clog2(COLS) | Start column of a new burst |
| wr_data | input | DW | Write beat data |
| wr_mask | input | DW/8 | Per-byte write mask, 1 keeps the stored byte |
| blen_sel | input | 2 | Burst length select: 1 shifted left by the value |
| rd_data | output | DW | Read beat data |
| rd_valid | output | 1 | Read data on `rd_data` is driven |
| busy | output | 1 | A burst is live |
| suspended | output | 1 | The current cycle ends on a frozen edge |

## Verification
The bench uses the defaults: 4 banks of 16 columns with a 16-bit word. That makes two byte lanes, enough for partial masks. Sixteen columns hold two aligned length-8 blocks, so wrap-around at every length is reachable from unaligned start columns. Directed phases cover suspend mid-read, mid-write, on the last read beat, and while idle, plus runs of back-to-back suspends and a burst cut short by a new command. A long pseudo-random phase then mixes commands, lengths and `cke` patterns against the behavioural model.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  typedef enum logic [1:0] {
    SBE_NOP   = 2'd0,
    SBE_READ  = 2'd1,
    SBE_WRITE = 2'd2,
    SBE_RSVD  = 2'd3
  } sbe_cmd_e;

  localparam int SBE_MAX_LEN = 8;
endpackage

// File: rtl/sbe_array.sv
module sbe_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] wmask,
  output logic [DW-1:0]   rdat
);
  localparam int DEPTH = 1 << AW;
  localparam int NB    = DW / 8;

  for (genvar ln = 0; ln < NB; ln++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) lane_mem[i] <= '0;
      end else if (we && !wmask[ln]) begin
        lane_mem[addr] <= wdata[ln*8 +: 8];
      end
    end

    assign rdat[ln*8 +: 8] = lane_mem[addr];
  end
endmodule

// File: rtl/sbe_beat_ctr.sv
module sbe_beat_ctr #(
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       len_sel,
  output logic             fire,
  output logic [COL_W-1:0] beat_col,
  output logic             act_q,
  output logic             act_nxt
);
  import sbe_pkg::*;
  localparam int CNT_W = $clog2(SBE_MAX_LEN) + 1;

  logic [CNT_W-1:0] cnt_q, len_q, len_now, idx, cnt_nxt;
  logic [COL_W-1:0] start_q, start_now, lmask;
  logic             act_calc;

  always_comb begin
    len_now   = load ? (CNT_W'(1) << len_sel) : len_q;
    start_now = load ? start_col : start_q;
    idx       = load ? '0 : cnt_q;
    lmask     = COL_W'(len_now - CNT_W'(1));
    beat_col  = (start_now & ~lmask) | ((start_now + COL_W'(idx)) & lmask);
    cnt_nxt   = idx + CNT_W'(1);
    act_calc  = cnt_nxt < len_now;
    fire      = step && (load || act_q);
    act_nxt   = fire ? act_calc : act_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      len_q   <= CNT_W'(1);
      start_q <= '0;
      act_q   <= 1'b0;
    end else if (fire) begin
      cnt_q   <= cnt_nxt;
      len_q   <= len_now;
      start_q <= start_now;
      act_q   <= act_calc;
    end
  end

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(cnt_q) && $stable(act_q) && $stable(start_q)));
endmodule

// File: rtl/sbe_susp_ctl.sv
module sbe_susp_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic live_nxt,
  output logic frz
);
  always_ff @(posedge clk) begin
    if (!rst_n) frz <= 1'b0;
    else        frz <= !cke && live_nxt;
  end

  // R7
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> !frz);

  // R4
  susp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frz |-> !$past(cke));
endmodule

// File: rtl/sbe_burst_engine.sv
module sbe_burst_engine #(
  parameter int BANKS = 4,
  parameter int COLS  = 16,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke,
  input  logic [1:0]               cmd,
  input  logic [$clog2(BANKS)-1:0] bank,
  input  logic [$clog2(COLS)-1:0]  col,
  input  logic [DW-1:0]            wr_data,
  input  logic [DW/8-1:0]          wr_mask,
  input  logic [1:0]               blen_sel,
  output logic [DW-1:0]            rd_data,
  output logic                     rd_valid,
  output logic                     busy,
  output logic                     suspended
);
  import sbe_pkg::*;
  localparam int BA_W  = $clog2(BANKS);
  localparam int COL_W = $clog2(COLS);
  localparam int AW    = BA_W + COL_W;

  sbe_cmd_e         cmd_e;
  logic             frz, step, load, is_rd, is_wr;
  logic             wr_q, wr_now, fire, act_q, act_nxt;
  logic             rd_fire, we, oe_nxt, live_nxt;
  logic [BA_W-1:0]  bank_q, bank_now;
  logic [COL_W-1:0] beat_col;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    rdat, rd_q;
  logic             oe_q;

  always_comb begin
    cmd_e    = sbe_cmd_e'(cmd);
    is_rd    = cmd_e == SBE_READ;
    is_wr    = cmd_e == SBE_WRITE;
    step     = !frz;
    load     = step && (is_rd || is_wr);
    wr_now   = load ? is_wr : wr_q;
    bank_now = load ? bank : bank_q;
    addr     = {bank_now, beat_col};
    we       = fire && wr_now;
    rd_fire  = fire && !wr_now;
    oe_nxt   = step ? rd_fire : oe_q;
    live_nxt = act_nxt || oe_nxt;
  end

  sbe_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .step(step), .load(load),
    .start_col(col), .len_sel(blen_sel), .fire(fire),
    .beat_col(beat_col), .act_q(act_q), .act_nxt(act_nxt)
  );

  sbe_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr),
    .wdata(wr_data), .wmask(wr_mask), .rdat(rdat)
  );

  sbe_susp_ctl u_susp (
    .clk(clk), .rst_n(rst_n), .cke(cke), .live_nxt(live_nxt), .frz(frz)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      bank_q <= '0;
    end else if (load) begin
      wr_q   <= is_wr;
      bank_q <= bank;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
      oe_q <= 1'b0;
    end else if (step) begin
      oe_q <= rd_fire;
      if (rd_fire) rd_q <= rdat;
    end
  end

  assign rd_data   = rd_q;
  assign rd_valid  = oe_q;
  assign busy      = act_q || oe_q;
  assign suspended = frz;

  // R5
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |=> ($stable(rd_data) && $stable(rd_valid) && $stable(busy)));

  // R8
  idle_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !suspended && !cke && !is_rd && !is_wr) |=> !suspended);

  // R10
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);
endmodule

// File: tb/tb_sbe_burst_engine.sv
`timescale 1ns/1ps
module tb_sbe_burst_engine;
  localparam int BANKS = 4, COLS = 16, DW = 16, NB = DW / 8;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic [1:0] cmd = '0, blen_sel = '0;
  logic [1:0] bank = '0;
  logic [3:0] col = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] wr_mask = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, busy, suspended;

  always #2.5 clk = ~clk;

  sbe_burst_engine #(.BANKS(BANKS), .COLS(COLS), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank(bank), .col(col),
    .wr_data(wr_data), .wr_mask(wr_mask), .blen_sel(blen_sel),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .suspended(suspended)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string phase = "R1";

  logic [DW-1:0] mm [BANKS*COLS];
  int m_cnt, m_len, m_start, m_bank;
  bit m_wr, m_act, m_oe, m_frz;
  logic [DW-1:0] m_rd;

  function automatic int colof(int s, int i, int l);
    return (s & ~(l - 1)) | ((s + i) & (l - 1));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BANKS*COLS; i++) mm[i] = '0;
      m_cnt = 0; m_len = 1; m_start = 0; m_bank = 0;
      m_wr = 0; m_act = 0; m_oe = 0; m_frz = 0; m_rd = '0;
    end else begin
      if (!m_frz) begin
        if (cmd == 2'd1 || cmd == 2'd2) begin
          m_wr = (cmd == 2'd2); m_bank = bank; m_start = col;
          m_len = 1 << blen_sel; m_cnt = 0; m_act = 1;
        end
        if (m_act) begin
          int a;
          a = m_bank * COLS + colof(m_start, m_cnt, m_len);
          if (m_wr) begin
            for (int j = 0; j < NB; j++)
              if (!wr_mask[j]) mm[a][j*8 +: 8] = wr_data[j*8 +: 8];
            m_oe = 0;
          end else begin
            m_rd = mm[a]; m_oe = 1;
          end
          m_cnt++;
          m_act = m_cnt < m_len;
        end else begin
          m_oe = 0;
        end
      end
      m_frz = !cke && (m_act || m_oe);
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, "rd_valid", rd_valid, m_oe);
      chk(phase, "busy R10", busy, m_act || m_oe);
      chk(phase, "suspended", suspended, m_frz);
      if (m_oe) chk(phase, "rd_data", rd_data, m_rd);
    end
  end

  task automatic drv(int c, int b, int co, int wd, int wm, bit k);
    @(negedge clk); #1;
    cmd = c[1:0]; bank = b[1:0]; col = co[3:0];
    wr_data = wd[DW-1:0]; wr_mask = wm[NB-1:0]; cke = k;
  endtask

  task automatic nops(int n, bit k);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 16'hDEAD, 0, k);
  endtask

  task automatic summary();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset rd_valid", rd_valid, 0);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset suspended", suspended, 0);
    #1 rst_n = 1;
    // R1: zero contents after reset, read one length-8 block
    blen_sel = 3; drv(1, 2, 8, 0, 0, 1); nops(9, 1);

    phase = "R3";
    blen_sel = 3; drv(2, 0, 0, 16'h1000, 0, 1);
    for (int i = 1; i < 8; i++) drv(0, 0, 0, 16'h1000 + i, 0, 1);
    blen_sel = 2; drv(2, 1, 6, 16'h2006, 0, 1);
    for (int i = 1; i < 4; i++) drv(0, 1, 0, 16'h2006 + i, 0, 1);
    blen_sel = 0; drv(2, 0, 3, 16'hABCD, 2'b01, 1);
    drv(2, 0, 4, 16'h55AA, 2'b10, 1);
    nops(2, 1);

    phase = "R2";
    for (int l = 0; l < 4; l++) begin
      blen_sel = l[1:0]; drv(1, 0, 5, 0, 0, 1); nops(9, 1);
    end
    blen_sel = 2; drv(1, 1, 6, 0, 0, 1); nops(6, 1);
    blen_sel = 1; drv(1, 1, 7, 0, 0, 1); nops(3, 1);

    phase = "R4 R5";
    blen_sel = 3; drv(1, 0, 2, 0, 0, 1);
    drv(0, 0, 0, 0, 0, 1); drv(0, 0, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 0, 0); drv(0, 0, 0, 0, 0, 0);
    nops(3, 1); drv(0, 0, 0, 0, 0, 0); nops(6, 1);

    phase = "R6";
    blen_sel = 3; drv(2, 3, 0, 16'h3000, 0, 0);
    drv(1, 2, 9, 16'hBAD0, 0, 0);
    drv(2, 1, 1, 16'hBAD1, 2'b11, 1);
    drv(0, 0, 0, 16'h3001, 0, 1);
    drv(0, 0, 0, 16'h3002, 0, 0);
    drv(2, 0, 0, 16'hBAD2, 0, 1);
    for (int i = 3; i < 8; i++) drv(0, 0, 0, 16'h3000 + i, 0, 1);
    nops(2, 1);
    drv(1, 3, 0, 0, 0, 1); nops(9, 1);

    phase = "R7";
    blen_sel = 2; drv(1, 0, 1, 0, 0, 1);
    drv(0, 0, 0, 0, 0, 0); drv(0, 0, 0, 0, 0, 1);
    drv(0, 0, 0, 0, 0, 0); drv(0, 0, 0, 0, 0, 1);
    drv(0, 0, 0, 0, 0, 0); drv(0, 0, 0, 0, 0, 0);
    nops(4, 1);

    phase = "R8";
    nops(5, 0);
    drv(3, 1, 2, 0, 0, 0); nops(2, 0);
    blen_sel = 0; drv(1, 0, 3, 0, 0, 1); nops(3, 1);

    phase = "R9";
    blen_sel = 3; drv(1, 0, 0, 0, 0, 1); nops(2, 1);
    drv(2, 2, 12, 16'h4444, 0, 1); drv(0, 0, 0, 16'h4445, 0, 1);
    blen_sel = 1; drv(1, 2, 13, 0, 0, 1); nops(1, 1);
    drv(1, 0, 7, 0, 0, 1); nops(4, 1);

    phase = "R10";
    for (int i = 0; i < 3000; i++) begin
      int r, c;
      r = $urandom % 100;
      c = (r < 12) ? 1 : (r < 22) ? 2 : (r < 25) ? 3 : 0;
      @(negedge clk); #1;
      cmd = c[1:0]; bank = 2'($urandom); col = 4'($urandom);
      wr_data = 16'($urandom); wr_mask = 2'($urandom);
      blen_sel = 2'($urandom); cke = ($urandom % 100) < 70;
    end
    nops(12, 1);
    for (int b = 0; b < BANKS; b++)
      for (int h = 0; h < 2; h++) begin
        blen_sel = 3; drv(1, b, h * 8, 0, 0, 1); nops(8, 1);
      end
    nops(2, 1);
    summary();
  end
endmodule